// File: doc/BRIEF.md
# TDM Serial Port Frame Engine

This block drives a time-division multiplexed serial port that runs on its own bit clock. A frame holds twelve 16-bit slots. The first slot carries a control word inbound and a status word outbound. The second slot carries register data in both directions. The remaining ten slots carry five stereo sample pairs, right channel first. On the outbound side the engine takes a parallel image of all twelve slots and serialises it MSB first. On the inbound side it collects the serial input into twelve parallel words and decodes the control word once per frame.

At the highest rate a frame is exactly 192 bit clocks long. A 3-bit select can slow the frame to one of five channel rates. Each rate is given as a period in bit clocks with four fractional bits. A phase accumulator decides how many idle bit clocks follow the last slot of each frame. Because the fraction is carried from frame to frame, the average frame length matches the chosen period exactly. A one-cycle frame sync marks the cycle just before the first data bit.

Every frame ends with exactly one indirect register access request, either a read or a write. The request carries the address taken from the control word. The activity bit of the control word is held for a power-down timer outside the block.

Top module: `tdm_frame_engine`

## Requirements
- R1: While reset is held and in the first cycle after release, `fsync` is 1. In that same first cycle, `sdo`, `frameDone`, `regRd`, `regWr` and `alive` are 0 and `rxWords` is all zero.
- R2: With `rateSel` at 0, 6 or 7 (maximum rate), consecutive `fsync` pulses are exactly 192 bit clocks apart.
- R3: `fsync` is high for exactly one cycle per frame, and the first data bit goes out in the cycle right after it.
- R4: In data cycle k (k = 0..191, counted from the cycle after `fsync`), `sdo` carries bit 15-(k mod 16) of slot k/16, where slot i is `txWords[i*16 +: 16]`. In idle padding cycles `sdo` is 0.
- R5: `txWords` is captured at the clock edge that ends the `fsync` cycle. Changes to `txWords` after that edge do not affect the frame being sent.
- R6: `sdi` is sampled in data cycle k and becomes bit 15-(k mod 16) of `rxWords[(k/16)*16 +: 16]`. `rxWords` changes only at the edge that ends data cycle 191. `frameDone` is a one-cycle pulse in the cycle that follows that edge.
- R7: `rxWords` slot 0 is the control word. Its fields are decoded as: `ctlFlush` = bit 15; `subValid[4:0]` = bits 12:8, with `subValid[4]` for capture and `subValid[0]` for I2S port 0; `alive` = bit 7; `regAddr` = bits 5:0.
- R8: In each `frameDone` cycle exactly one of `regRd` and `regWr` is 1. `regRd` is chosen when control bit 6 is 1, and `regWr` when it is 0. Both are 0 in every other cycle.
- R9: `rateSel` values 1 to 5 select `ratePeriods[(rateSel-1)*16 +: 16]`: 1 capture, 2 playback, 3 FM, 4 I2S port 1, 5 I2S port 0. A period has four fractional bits. Maximum rate uses the period 192.0. At each frame start, sum = carried fraction + period. The frame length is the integer part of the sum, and the fractional part of the sum is carried to the next frame.
- R10: If the integer part of that sum is below 192, the frame is 192 bit clocks long and the carried fraction is cleared.
- R11: `rateSel` only matters at the edge that ends an `fsync` cycle. Changes in between do not alter the length of the running frame.
- R12: `alive` and the other decoded fields change only in a `frameDone` cycle and hold their values until the next one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sdi | input | 1 | Serial data in |
| rateSel | input | 3 | Frame rate select |
| ratePeriods | input | 80 | Five rate periods, 12.4 fixed point, in bit clocks |
| txWords | input | 192 | Outbound slot images, slot i at [i*16 +: 16] |
| sdo | output | 1 | Serial data out |
| fsync | output | 1 | Frame sync pulse |
| rxWords | output | 192 | Inbound slot words, slot i at [i*16 +: 16] |
| frameDone | output | 1 | Inbound frame complete pulse |
| ctlFlush | output | 1 | Control word flush bit |
| subValid | output | 5 | Substitution-valid flags per channel pair |
| alive | output | 1 | Port activity indication |
| regRd | output | 1 | Indirect register read request |
| regWr | output | 1 | Indirect register write request |
| regAddr | output | 6 | Indirect register address |

## Verification
The bench builds the engine with its default geometry: 16-bit slots, twelve slots, and 16-bit periods with four fractional bits. It programs five periods: exactly 192, 200.5, 250.25, 193.75 and 190. Together these cover a frame with no padding, fractions that repeat every two, four and four frames, and a period below the minimum that forces the clamp. Rate and outbound words change at random points inside frames, so the bench shows that only the values present at the frame boundary take effect. Directed control words set every decoded field high or low, and random frames cover the rest.

// File: rtl/tdm_frame_pkg.sv
package tdm_frame_pkg;

  // Number of selectable slowed-down rates (besides maximum)
  localparam int unsigned NUM_RATES = 5;

  // Strobes from sequencing control to the shift datapath
  typedef struct packed {
    logic loadTx;   // frame boundary: capture outbound slot images
    logic shiftEn;  // a data bit is on the line this cycle
    logic latchRx;  // last data bit of the frame is on the line
  } tdmStrobe_t;

endpackage

// File: rtl/tdm_frame_ctrl.sv
module tdm_frame_ctrl
  import tdm_frame_pkg::*;
#(
  parameter int unsigned FRAME_BITS = 192,
  parameter int unsigned PER_W      = 16,
  parameter int unsigned FRAC_W     = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [2:0]                    rateSel,
  input  logic [NUM_RATES*PER_W-1:0]    ratePeriods,
  output logic                          fsync,
  output tdmStrobe_t                    strobe
);

  localparam int unsigned BIT_W = $clog2(FRAME_BITS);
  localparam int unsigned PAD_W = PER_W - FRAC_W + 1;
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(FRAME_BITS - 1);
  localparam logic [PER_W-1:0] MAX_PERIOD = PER_W'(FRAME_BITS * (2 ** FRAC_W));
  localparam logic [PAD_W-1:0] MIN_LEN = PAD_W'(FRAME_BITS);

  logic              inPad;
  logic [BIT_W-1:0]  bitCnt;
  logic [PAD_W-1:0]  padCnt;
  logic [PAD_W-1:0]  padLen;
  logic [FRAC_W-1:0] accFrac;

  logic [PER_W-1:0]  selPeriod;
  logic [PER_W:0]    phaseSum;
  logic [PAD_W-1:0]  wholePart;
  logic [PAD_W-1:0]  padNext;
  logic [FRAC_W-1:0] fracNext;
  logic              lastBit;

  // Period of the selected rate; unknown codes fall back to maximum rate
  always_comb begin
    selPeriod = MAX_PERIOD;
    for (int j = 0; j < int'(NUM_RATES); j++) begin
      if (rateSel == 3'(j + 1)) selPeriod = ratePeriods[j*PER_W +: PER_W];
    end
  end

  // Phase accumulator: next frame length and carried fraction
  always_comb begin
    phaseSum  = {1'b0, selPeriod} + (PER_W+1)'(accFrac);
    wholePart = phaseSum[PER_W:FRAC_W];
    if (wholePart < MIN_LEN) begin
      padNext  = '0;
      fracNext = '0;
    end else begin
      padNext  = wholePart - MIN_LEN;
      fracNext = phaseSum[FRAC_W-1:0];
    end
  end

  assign lastBit = !inPad && (bitCnt == LAST_BIT);
  assign fsync   = inPad ? (padCnt == PAD_W'(1)) : (lastBit && (padLen == '0));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      inPad   <= 1'b1;
      padCnt  <= PAD_W'(1);
      padLen  <= '0;
      bitCnt  <= '0;
      accFrac <= '0;
    end else if (fsync) begin
      inPad   <= 1'b0;
      bitCnt  <= '0;
      padLen  <= padNext;
      accFrac <= fracNext;
    end else if (!inPad) begin
      if (lastBit) begin
        inPad  <= 1'b1;
        padCnt <= padLen;
        bitCnt <= '0;
      end else begin
        bitCnt <= bitCnt + 1'b1;
      end
    end else begin
      padCnt <= padCnt - 1'b1;
    end
  end

  always_comb begin
    strobe.loadTx  = fsync;
    strobe.shiftEn = !inPad;
    strobe.latchRx = lastBit;
  end

endmodule

// File: rtl/tdm_frame_dp.sv
module tdm_frame_dp
  import tdm_frame_pkg::*;
#(
  parameter int unsigned SLOT_W = 16,
  parameter int unsigned NSLOT  = 12
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      sdi,
  input  logic [SLOT_W*NSLOT-1:0]   txWords,
  input  tdmStrobe_t                strobe,
  output logic                      sdo,
  output logic [SLOT_W*NSLOT-1:0]   rxWords,
  output logic                      frameDone,
  output logic                      ctlFlush,
  output logic [4:0]                subValid,
  output logic                      alive,
  output logic                      regRd,
  output logic                      regWr,
  output logic [5:0]                regAddr
);

  localparam int unsigned FRAME_BITS = SLOT_W * NSLOT;

  logic [FRAME_BITS-1:0] txSerial;
  logic [FRAME_BITS-1:0] txShift;
  logic [FRAME_BITS-2:0] rxShift;
  logic [FRAME_BITS-1:0] rxFull;
  logic [FRAME_BITS-1:0] rxOrdered;

  assign rxFull = {rxShift, sdi};

  // Slot 0 goes out first: reorder between port layout and line order
  for (genvar i = 0; i < int'(NSLOT); i++) begin : g_slotMap
    assign txSerial[(NSLOT-1-i)*SLOT_W +: SLOT_W]  = txWords[i*SLOT_W +: SLOT_W];
    assign rxOrdered[i*SLOT_W +: SLOT_W]           = rxFull[(NSLOT-1-i)*SLOT_W +: SLOT_W];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      txShift <= '0;
    end else if (strobe.loadTx) begin
      txShift <= txSerial;
    end else if (strobe.shiftEn) begin
      txShift <= {txShift[FRAME_BITS-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rxShift   <= '0;
      rxWords   <= '0;
      frameDone <= 1'b0;
    end else begin
      if (strobe.shiftEn) rxShift <= rxFull[FRAME_BITS-2:0];
      if (strobe.latchRx) rxWords <= rxOrdered;
      frameDone <= strobe.latchRx;
    end
  end

  assign sdo = strobe.shiftEn ? txShift[FRAME_BITS-1] : 1'b0;

  // Control word field decode from inbound slot 0
  assign ctlFlush = rxWords[15];
  assign subValid = rxWords[12:8];
  assign alive    = rxWords[7];
  assign regAddr  = rxWords[5:0];
  assign regRd    = frameDone &  rxWords[6];
  assign regWr    = frameDone & ~rxWords[6];

endmodule

// File: rtl/tdm_frame_engine.sv
module tdm_frame_engine
  import tdm_frame_pkg::*;
#(
  parameter int unsigned SLOT_W = 16,
  parameter int unsigned NSLOT  = 12,
  parameter int unsigned PER_W  = 16,
  parameter int unsigned FRAC_W = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          sdi,
  input  logic [2:0]                    rateSel,
  input  logic [NUM_RATES*PER_W-1:0]    ratePeriods,
  input  logic [SLOT_W*NSLOT-1:0]       txWords,
  output logic                          sdo,
  output logic                          fsync,
  output logic [SLOT_W*NSLOT-1:0]       rxWords,
  output logic                          frameDone,
  output logic                          ctlFlush,
  output logic [4:0]                    subValid,
  output logic                          alive,
  output logic                          regRd,
  output logic                          regWr,
  output logic [5:0]                    regAddr
);

  tdmStrobe_t strobe;

  tdm_frame_ctrl #(
    .FRAME_BITS (SLOT_W * NSLOT),
    .PER_W      (PER_W),
    .FRAC_W     (FRAC_W)
  ) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .rateSel     (rateSel),
    .ratePeriods (ratePeriods),
    .fsync       (fsync),
    .strobe      (strobe)
  );

  tdm_frame_dp #(
    .SLOT_W (SLOT_W),
    .NSLOT  (NSLOT)
  ) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .sdi       (sdi),
    .txWords   (txWords),
    .strobe    (strobe),
    .sdo       (sdo),
    .rxWords   (rxWords),
    .frameDone (frameDone),
    .ctlFlush  (ctlFlush),
    .subValid  (subValid),
    .alive     (alive),
    .regRd     (regRd),
    .regWr     (regWr),
    .regAddr   (regAddr)
  );

endmodule

// File: rtl/tdm_frame_engine_chk.sv
module tdm_frame_engine_chk #(
  parameter int unsigned SLOT_W = 16,
  parameter int unsigned NSLOT  = 12
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     fsync,
  input logic                     frameDone,
  input logic                     regRd,
  input logic                     regWr,
  input logic                     alive,
  input logic [SLOT_W*NSLOT-1:0]  rxWords
);

  AST_SYNC_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    fsync |=> !fsync);                                      // R3

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    frameDone |=> !frameDone);                              // R6

  AST_RX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !frameDone |-> $stable(rxWords));                       // R6

  AST_ONE_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    frameDone |-> (regRd != regWr));                        // R8

  AST_NO_STRAY_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    !frameDone |-> !(regRd || regWr));                      // R8

  AST_ALIVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !frameDone |-> $stable(alive));                         // R12

endmodule

bind tdm_frame_engine tdm_frame_engine_chk #(
  .SLOT_W (SLOT_W),
  .NSLOT  (NSLOT)
) u_chk (.*);

// File: tb/tdm_frame_engine_bench.sv
module tdm_frame_engine_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NFRAMES    = 120;
  localparam int WATCHDOG   = 150000;
  localparam int FBITS      = 192;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         sdi = 1'b0;
  logic [2:0]   rateSel = 3'd0;
  logic [79:0]  ratePeriods;
  logic [191:0] txWords = '0;
  logic         sdo, fsync, frameDone, ctlFlush, alive, regRd, regWr;
  logic [191:0] rxWords;
  logic [4:0]   subValid;
  logic [5:0]   regAddr;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int frames = 0;
  int benchFrac = 0;
  int per [5] = '{3072, 3208, 4004, 3100, 3040};

  logic [191:0] txSnap, rxSent, rxChk;
  bit  inFrame = 0, pending = 0, first = 1;
  int  bitIdx = 0, sinceSync = 0, expLen = 0;
  bit  expAlive = 0;

  tdm_frame_engine u_tdm_frame_engine (
    .clk(clk), .rst_n(rst_n), .sdi(sdi), .rateSel(rateSel),
    .ratePeriods(ratePeriods), .txWords(txWords), .sdo(sdo), .fsync(fsync),
    .rxWords(rxWords), .frameDone(frameDone), .ctlFlush(ctlFlush),
    .subValid(subValid), .alive(alive), .regRd(regRd), .regWr(regWr),
    .regAddr(regAddr)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [191:0] act, input logic [191:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s cycle=%0d actual=%h expected=%h", req, cyc, act, exp);
    end
  endtask

  function automatic int modelLen(input logic [2:0] sel);
    int p, sum, ip;
    p = (sel >= 3'd1 && sel <= 3'd5) ? per[sel-1] : FBITS * 16;
    sum = benchFrac + p;
    ip = sum >> 4;
    if (ip < FBITS) begin
      benchFrac = 0;
      return FBITS;
    end
    benchFrac = sum & 15;
    return ip;
  endfunction

  function automatic logic lineBit(input logic [191:0] v, input int k);
    return v[(k/16)*16 + 15 - (k%16)];
  endfunction

  function automatic logic [191:0] randFrame(input int n);
    logic [191:0] v;
    for (int i = 0; i < 6; i++) v[i*32 +: 32] = $urandom;
    case (n)
      0: v[15:0] = 16'h0000;
      1: v[15:0] = 16'hFFFF;
      2: v[15:0] = 16'h1A85;
      3: v[15:0] = 16'h80C0;
      default: ;
    endcase
    return v;
  endfunction

  function automatic logic [2:0] pickRate();
    if (frames < 12) begin
      case ($urandom % 3)
        0: return 3'd0;
        1: return 3'd6;
        default: return 3'd7;
      endcase
    end
    return 3'($urandom % 8);
  endfunction

  task automatic stepCycle();
    logic [15:0] w;
    cyc++;
    if (pending) begin
      w = rxChk[15:0];
      chk(frameDone == 1'b1, "R6 frameDone pulse", {191'd0, frameDone}, 192'd1);
      chk(rxWords == rxChk, "R6 rxWords", rxWords, rxChk);
      chk(ctlFlush == w[15] && subValid == w[12:8] && regAddr == w[5:0],
          "R7 field decode", {ctlFlush, subValid, regAddr}, {w[15], w[12:8], w[5:0]});
      chk(regRd == w[6] && regWr == !w[6], "R8 access kind", {regRd, regWr}, {w[6], !w[6]});
      expAlive = w[7];
      pending = 0;
    end else begin
      chk(!frameDone && !regRd && !regWr, "R8 no access outside frameDone",
          {frameDone, regRd, regWr}, 192'd0);
    end
    chk(alive == expAlive, "R12 alive hold", {191'd0, alive}, {191'd0, expAlive});
    if (inFrame) begin
      chk(sdo == lineBit(txSnap, bitIdx), "R4 R5 sdo data bit",
          {191'd0, sdo}, {191'd0, lineBit(txSnap, bitIdx)});
      sdi = lineBit(rxSent, bitIdx);
      bitIdx++;
      if (bitIdx == FBITS) begin
        inFrame = 0;
        pending = 1;
        rxChk = rxSent;
      end
    end else begin
      chk(sdo == 1'b0, "R4 idle sdo", {191'd0, sdo}, 192'd0);
    end
    sinceSync++;
    if (fsync) begin
      if (!first) begin
        if (expLen == FBITS)
          chk(sinceSync == expLen, "R2 R10 frame length", 192'(sinceSync), 192'(expLen));
        else
          chk(sinceSync == expLen, "R9 R11 frame length", 192'(sinceSync), 192'(expLen));
      end
      chk(!inFrame, "R3 sync before first bit", {191'd0, inFrame}, 192'd0);
      first = 0;
      expLen = modelLen(rateSel);
      txSnap = txWords;
      rxSent = randFrame(frames);
      inFrame = 1;
      bitIdx = 0;
      sinceSync = 0;
      frames++;
    end else begin
      if ($urandom % 5 == 0) for (int i = 0; i < 6; i++) txWords[i*32 +: 32] = $urandom;
      if ($urandom % 97 == 0) rateSel = pickRate();
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    for (int j = 0; j < 5; j++) ratePeriods[j*16 +: 16] = 16'(per[j]);
    for (int i = 0; i < 6; i++) txWords[i*32 +: 32] = $urandom;
    repeat (4) @(negedge clk);
    chk(fsync == 1'b1, "R1 fsync during reset", {191'd0, fsync}, 192'd1);
    rst_n = 1'b1;
    chk(fsync == 1'b1 && sdo == 1'b0 && !frameDone && !alive && !regRd && !regWr,
        "R1 reset outputs", {fsync, sdo, frameDone, alive, regRd, regWr}, 192'b100000);
    chk(rxWords == '0, "R1 rxWords reset", rxWords, 192'd0);
    stepCycle();
    while (frames < NFRAMES && cyc < WATCHDOG) begin
      @(negedge clk);
      stepCycle();
    end
    if (cyc >= WATCHDOG) chk(1'b0, "watchdog expired", 192'(cyc), 192'(WATCHDOG));
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule